// File: doc/BRIEF.md
# I2C Memory Target Front End

This block sits between the two I2C bus lines and the write buffer of a small byte-addressed serial memory. It runs on a system clock that oversamples SCL and SDA. It passes both lines through a synchroniser and a glitch filter. From the filtered lines it detects START and STOP conditions and the SCL edges. After a START it shifts in a control byte and compares the upper nibble with a fixed device code. The next three bits select nothing and are ignored. The low bit gives the direction.

A write control byte is acknowledged unless the downstream buffer reports that its internal write cycle is busy. The next byte is loaded into a word address pointer. Every byte after that is acknowledged and handed to the buffer as a one-cycle strobe, together with the current pointer. The low pointer bits then advance and wrap inside a page. A STOP that ends an acknowledged write transfer is passed on as a one-cycle pulse. Read control bytes are not acknowledged, and the bus is ignored until the next START or STOP. The open-drain SDA pull-down is represented by the output enable `sda_oe_o`.

States: `ST_IDLE` (bus free), `ST_CTRL` (shifting the control byte), `ST_CTRL_ACK`, `ST_ADDR` (shifting the word address), `ST_ADDR_ACK`, `ST_DATA` (shifting a data byte), `ST_DATA_ACK`, and `ST_SKIP` (not addressed, waiting).

Transitions:
- Any state goes to `ST_CTRL` on START and to `ST_IDLE` on STOP.
- `ST_CTRL` goes to `ST_CTRL_ACK` on a match and to `ST_SKIP` on a mismatch. The decision is made at the SCL fall that ends the eighth bit.
- `ST_ADDR` goes to `ST_ADDR_ACK`, and `ST_DATA` goes to `ST_DATA_ACK`, at that same eighth fall.
- `ST_CTRL_ACK` goes to `ST_ADDR`, while `ST_ADDR_ACK` and `ST_DATA_ACK` go to `ST_DATA`. Each of these moves happens at the SCL fall that ends the ninth clock.

Top module: `i2c_mem_target`

## Requirements
- R1: A control byte is acknowledged only when its bits 7:4 (the first four bits received, MSB first) equal 4'b1010. On any other code there is no acknowledge and no write strobe until the next START.
- R2: Bits 3:1 of the control byte do not affect matching. For example, 8'hAE is acknowledged and its transfer proceeds like 8'hA0.
- R3: Bit 0 of the control byte selects the direction: 0 is write, 1 is read. A read control byte is not acknowledged, and the bytes after it produce no write strobe.
- R4: An acknowledge raises `sda_oe_o` after the SCL fall that ends the eighth bit and drops it after the SCL fall that ends the ninth clock. `sda_oe_o` changes only while the filtered SCL is low and is 0 whenever no acknowledge is due.
- R5: If `wr_busy_i` is 1 when the control byte is decided, that byte gets no acknowledge.
- R6: In a write transfer, the byte after the control byte is acknowledged and loaded into the word address pointer.
- R7: Each byte after the word address is acknowledged and output on `wr_data_o`, with `wr_addr_o` equal to the pointer, for exactly one cycle of `wr_valid_o`.
- R8: After each data byte, the low PAGE_BITS (3) bits of the pointer increment modulo 8 and the upper bits stay unchanged. For example, starting at 8'h3D the addresses are 3D, 3E, 3F, 38.
- R9: A STOP that arrives after an acknowledged write control byte pulses `wr_stop_o` for one cycle. A STOP in any other situation gives no pulse, and `wr_stop_o` is never high together with `wr_valid_o`.
- R10: A START in the middle of a byte drops the partial byte without a strobe and restarts control-byte reception.
- R11: After reset, `sda_oe_o`, `wr_valid_o` and `wr_stop_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| wr_busy_i | input | 1 | Downstream internal write cycle in progress |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge) |
| wr_valid_o | output | 1 | One-cycle strobe for a received data byte |
| wr_addr_o | output | ADDR_W (8) | Word address for the strobed byte |
| wr_data_o | output | 8 | Strobed data byte |
| wr_stop_o | output | 1 | One-cycle pulse: write transfer ended by STOP |

## Verification
Two events can fall in the same cycle.

The first pair is the control-byte decision and a change of the busy input. The bench raises `wr_busy_i` at the very moment it pulls SCL low after the eighth control bit. The busy flag must be seen at the decision, so the expected result is no acknowledge.

The second pair is a data strobe and the page wrap of the pointer. A ten-byte page write starts at 8'h3D. The strobe for the byte at 8'h3F must still carry 3F, and the next strobe must carry 38. The behavioural model in the bench predicts the acknowledge level in every settled cycle and the exact sequence of address/data pairs.

// File: rtl/i2c_mem_target_pkg.sv
package i2c_mem_target_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP
    } tgt_state_e;

    localparam int BYTE_BITS = 8;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int SYNC_LEN = 2,
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);

    logic [SYNC_LEN-1:0] sync_q;
    logic [CNT_W-1:0]    cnt_q;
    logic                raw;

    assign raw = sync_q[SYNC_LEN-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            cnt_q  <= '0;
            line_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_LEN-2:0], line_i};
            if (raw == line_o) begin
                cnt_q <= '0;
            end else if (cnt_q == CNT_W'(FILT_LEN - 1)) begin
                line_o <= raw;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign start_o = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_o  = scl_f & scl_q & ~sda_q & sda_f;
    assign rise_o  = scl_f & ~scl_q;
    assign fall_o  = ~scl_f & scl_q;

endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
    import i2c_mem_target_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          PAGE_BITS = 3,
    parameter int          SYNC_LEN  = 2,
    parameter int          FILT_LEN  = 3,
    parameter logic [3:0]  DEV_CODE  = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              wr_busy_i,
    output logic              sda_oe_o,
    output logic              wr_valid_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o,
    output logic              wr_stop_o
);
    localparam int CNT_W = $clog2(BYTE_BITS + 1);

    logic [1:0] raw_lines, flt_lines;
    logic       scl_f, sda_f;
    logic       ev_start, ev_stop, ev_rise, ev_fall;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        i2c_line_filter #(.SYNC_LEN(SYNC_LEN), .FILT_LEN(FILT_LEN)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_o (flt_lines[g])
        );
    end

    assign scl_f = flt_lines[1];
    assign sda_f = flt_lines[0];

    i2c_bus_events u_ev (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f   (scl_f),
        .sda_f   (sda_f),
        .start_o (ev_start),
        .stop_o  (ev_stop),
        .rise_o  (ev_rise),
        .fall_o  (ev_fall)
    );

    tgt_state_e          state_q, state_d;
    logic [CNT_W-1:0]    cnt_q, cnt_d;
    logic [7:0]          shreg_q, shreg_d;
    logic [ADDR_W-1:0]   ptr_q, ptr_d;
    logic                oe_d, val_d, stop_d;
    logic [7:0]          data_d;
    logic [ADDR_W-1:0]   addr_d;
    logic                byte_full, ctrl_ok;
    logic [PAGE_BITS-1:0] page_nxt;

    assign byte_full = (cnt_q == CNT_W'(BYTE_BITS));
    assign ctrl_ok   = (shreg_q[7:4] == DEV_CODE) && !shreg_q[0] && !wr_busy_i;
    assign page_nxt  = ptr_q[PAGE_BITS-1:0] + PAGE_BITS'(1);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        shreg_d = shreg_q;
        ptr_d   = ptr_q;
        oe_d    = sda_oe_o;
        val_d   = 1'b0;
        data_d  = wr_data_o;
        addr_d  = wr_addr_o;
        stop_d  = 1'b0;
        if (ev_start) begin
            state_d = ST_CTRL;
            cnt_d   = '0;
            oe_d    = 1'b0;
        end else if (ev_stop) begin
            state_d = ST_IDLE;
            oe_d    = 1'b0;
            stop_d  = (state_q == ST_ADDR) || (state_q == ST_ADDR_ACK) ||
                      (state_q == ST_DATA) || (state_q == ST_DATA_ACK);
        end else begin
            unique case (state_q)
                ST_CTRL, ST_ADDR, ST_DATA: begin
                    if (ev_rise && !byte_full) begin
                        shreg_d = {shreg_q[6:0], sda_f};
                        cnt_d   = cnt_q + 1'b1;
                    end else if (ev_fall && byte_full) begin
                        cnt_d = '0;
                        if (state_q == ST_CTRL) begin
                            state_d = ctrl_ok ? ST_CTRL_ACK : ST_SKIP;
                            oe_d    = ctrl_ok;
                        end else if (state_q == ST_ADDR) begin
                            state_d = ST_ADDR_ACK;
                            oe_d    = 1'b1;
                            ptr_d   = ADDR_W'(shreg_q);
                        end else begin
                            state_d = ST_DATA_ACK;
                            oe_d    = 1'b1;
                            val_d   = 1'b1;
                            data_d  = shreg_q;
                            addr_d  = ptr_q;
                            ptr_d   = {ptr_q[ADDR_W-1:PAGE_BITS], page_nxt};
                        end
                    end
                end
                ST_CTRL_ACK, ST_ADDR_ACK, ST_DATA_ACK: begin
                    if (ev_fall) begin
                        oe_d    = 1'b0;
                        cnt_d   = '0;
                        state_d = (state_q == ST_CTRL_ACK) ? ST_ADDR : ST_DATA;
                    end
                end
                ST_IDLE, ST_SKIP: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            shreg_q <= '0;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            shreg_q <= shreg_d;
            ptr_q   <= ptr_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe_o   <= 1'b0;
            wr_valid_o <= 1'b0;
            wr_data_o  <= '0;
            wr_addr_o  <= '0;
            wr_stop_o  <= 1'b0;
        end else begin
            sda_oe_o   <= oe_d;
            wr_valid_o <= val_d;
            wr_data_o  <= data_d;
            wr_addr_o  <= addr_d;
            wr_stop_o  <= stop_d;
        end
    end

endmodule

// File: rtl/i2c_mem_target_chk.sv
module i2c_mem_target_chk
    import i2c_mem_target_pkg::*;
#(
    parameter logic [3:0] DEV_CODE = 4'b1010
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_flt,
    input logic       wr_busy_i,
    input logic       sda_oe_o,
    input logic       wr_valid_o,
    input logic       wr_stop_o,
    input tgt_state_e state_q,
    input logic [7:0] shreg_q
);

    // R1
    ctrl_code_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe_o) && state_q == ST_CTRL_ACK) |-> (shreg_q[7:4] == DEV_CODE && !shreg_q[0]));

    // R4
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> !scl_flt);

    // R5
    busy_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe_o) && state_q == ST_CTRL_ACK) |-> !$past(wr_busy_i));

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |=> !wr_valid_o);

    // R9
    stop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stop_o |=> !wr_stop_o);

    // R9
    stop_vs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stop_o && wr_valid_o));

endmodule

bind i2c_mem_target i2c_mem_target_chk #(.DEV_CODE(DEV_CODE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_flt    (scl_f),
    .wr_busy_i  (wr_busy_i),
    .sda_oe_o   (sda_oe_o),
    .wr_valid_o (wr_valid_o),
    .wr_stop_o  (wr_stop_o),
    .state_q    (state_q),
    .shreg_q    (shreg_q)
);

// File: tb/tb_i2c_mem_target.sv
module tb_i2c_mem_target;
    localparam int Q     = 12;
    localparam int GUARD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1, m_sda = 1'b1, busy = 1'b0;
    logic       sda_line;
    logic       sda_oe_o, wr_valid_o, wr_stop_o;
    logic [7:0] wr_addr_o, wr_data_o;

    always #10 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe_o;

    i2c_mem_target dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_line),
        .wr_busy_i  (busy),
        .sda_oe_o   (sda_oe_o),
        .wr_valid_o (wr_valid_o),
        .wr_addr_o  (wr_addr_o),
        .wr_data_o  (wr_data_o),
        .wr_stop_o  (wr_stop_o)
    );

    int checks = 0, errors = 0;
    int cyc = 0, last_drv = 0;
    int exp_stops = 0, got_stops = 0;
    logic exp_oe = 1'b0;
    logic [15:0] exp_q[$];
    int m_phase = 3;
    logic [7:0] m_ptr = 8'h00;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // per-clock comparison against the behavioural model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (cyc - last_drv >= GUARD) begin
                checks++;
                if (sda_oe_o !== exp_oe) begin
                    errors++;
                    $display("FAIL R4 ack level cyc %0d: got %b exp %b", cyc, sda_oe_o, exp_oe);
                end
            end
            if (wr_valid_o) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R7 unexpected strobe: got %h/%h exp none", wr_addr_o, wr_data_o);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    if ({wr_addr_o, wr_data_o} !== e) begin
                        errors++;
                        $display("FAIL R7 R8 strobe: got %h/%h exp %h/%h",
                                 wr_addr_o, wr_data_o, e[15:8], e[7:0]);
                    end
                end
            end
            if (wr_stop_o) got_stops++;
        end
    end

    task automatic drive(input logic s, input logic d);
        m_scl = s;
        m_sda = d;
        last_drv = cyc;
    endtask

    task automatic wq();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic send_bit(input logic b, input logic oe_after, input logic busy_after);
        drive(1'b0, b);
        wq();
        drive(1'b1, b);
        wq();
        wq();
        drive(1'b0, b);
        exp_oe = oe_after;
        if (busy_after) busy = 1'b1;
    endtask

    task automatic start_c();
        drive(m_scl, 1'b1);
        wq();
        drive(1'b1, 1'b1);
        wq();
        drive(1'b1, 1'b0);
        wq();
        drive(1'b0, 1'b0);
        wq();
        m_phase = 0;
    endtask

    task automatic stop_c();
        drive(1'b0, 1'b0);
        wq();
        drive(1'b1, 1'b0);
        wq();
        drive(1'b1, 1'b1);
        wq();
        wq();
        if (m_phase == 1 || m_phase == 2) exp_stops++;
        m_phase = 3;
    endtask

    task automatic send_byte(input logic [7:0] b, input string req, input logic busy_at_fall);
        logic ack;
        case (m_phase)
            0: begin
                ack = (b[7:4] == 4'b1010) && !b[0] && !(busy || busy_at_fall);
                m_phase = ack ? 1 : 3;
            end
            1: begin ack = 1'b1; m_ptr = b; m_phase = 2; end
            2: begin
                ack = 1'b1;
                exp_q.push_back({m_ptr, b});
                m_ptr = {m_ptr[7:3], m_ptr[2:0] + 3'd1};
            end
            default: ack = 1'b0;
        endcase
        for (int i = 7; i >= 0; i--)
            send_bit(b[i], (i == 0) ? ack : 1'b0, (i == 0) ? busy_at_fall : 1'b0);
        wq();
        drive(1'b0, 1'b1);
        wq();
        drive(1'b1, 1'b1);
        wq();
        checks++;
        if (sda_line !== !ack) begin
            errors++;
            $display("FAIL %s ack on byte %h: got sda %b exp %b", req, b, sda_line, !ack);
        end
        wq();
        drive(1'b0, 1'b1);
        exp_oe = 1'b0;
        wq();
    endtask

    task automatic check_end(input string req);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s missing strobes: got %0d left exp 0", req, exp_q.size());
            exp_q.delete();
        end
        checks++;
        if (got_stops != exp_stops) begin
            errors++;
            $display("FAIL R9 stop pulses (%s): got %0d exp %0d", req, got_stops, exp_stops);
            got_stops = exp_stops;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #1;
        // R11 reset state
        checks++;
        if ({sda_oe_o, wr_valid_o, wr_stop_o} !== 3'b000) begin
            errors++;
            $display("FAIL R11 reset outputs: got %b exp 000", {sda_oe_o, wr_valid_o, wr_stop_o});
        end
        rst_n = 1'b1;
        last_drv = cyc;
        repeat (20) @(posedge clk);
        #1;

        // R1 R6 R7 R9 single byte write
        start_c();
        send_byte(8'hA0, "R1", 1'b0);
        send_byte(8'h10, "R6", 1'b0);
        send_byte(8'h55, "R7", 1'b0);
        stop_c();
        check_end("R7");

        // R2 chip-select bits ignored
        start_c();
        send_byte(8'hAE, "R2", 1'b0);
        send_byte(8'h22, "R6", 1'b0);
        send_byte(8'h66, "R2", 1'b0);
        send_byte(8'h99, "R2", 1'b0);
        stop_c();
        check_end("R2");

        // R1 wrong device code
        start_c();
        send_byte(8'hB0, "R1", 1'b0);
        send_byte(8'h01, "R1", 1'b0);
        send_byte(8'h02, "R1", 1'b0);
        stop_c();
        check_end("R1");

        // R3 read direction not acknowledged
        start_c();
        send_byte(8'hA1, "R3", 1'b0);
        send_byte(8'h05, "R3", 1'b0);
        stop_c();
        check_end("R3");

        // R5 busy held
        busy = 1'b1;
        start_c();
        send_byte(8'hA0, "R5", 1'b0);
        send_byte(8'h07, "R5", 1'b0);
        stop_c();
        check_end("R5");
        busy = 1'b0;

        // R8 page write with wrap
        start_c();
        send_byte(8'hA0, "R1", 1'b0);
        send_byte(8'h3D, "R6", 1'b0);
        for (int k = 0; k < 10; k++) send_byte(8'h80 + 8'(k), "R8", 1'b0);
        stop_c();
        check_end("R8");

        // R10 START in mid byte
        start_c();
        send_byte(8'hA0, "R1", 1'b0);
        send_byte(8'h40, "R6", 1'b0);
        send_bit(1'b1, 1'b0, 1'b0);
        send_bit(1'b0, 1'b0, 1'b0);
        send_bit(1'b1, 1'b0, 1'b0);
        send_bit(1'b1, 1'b0, 1'b0);
        wq();
        start_c();
        send_byte(8'hA0, "R10", 1'b0);
        send_byte(8'h48, "R10", 1'b0);
        send_byte(8'h77, "R10", 1'b0);
        stop_c();
        check_end("R10");

        // R5 busy rising together with the control-byte decision
        start_c();
        send_byte(8'hA0, "R5", 1'b1);
        send_byte(8'h11, "R5", 1'b0);
        stop_c();
        check_end("R5");
        busy = 1'b0;

        repeat (20) @(posedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule